// File: doc/BRIEF.md
# Register-Mapped Configurable I/O Port Bank

This block gives a processor core 32 general-purpose pins, arranged as four 8-bit ports, that software reaches through an ordinary register-file bus. Every port appears as a data register. Three further registers choose, per port, per nibble or per pin, whether a line is an input, a driven output or an address line. Changing the function of a line needs no special access sequence.

Each bit keeps its own output register apart from its input path. Software can therefore write a value while a bit is still an input. The value stays hidden and undriven until the bit is turned into an output, and from that cycle it is driven and read back. Pins are asynchronous, so each pin passes through two flip-flops before a read can return it. Port 2 has a mode in which a logic 1 releases the line instead of driving it high. Port 0 nibbles and port 1 can carry an external address bus, and a per-group flag reports when they do.

Top module: `io_port_bank`

## Requirements
- R1: After reset, every pin has its output enable low, every output register holds 0, open-drain mode is off, `addr_mode` is 0, and the mode registers read 0x49 (0xF8), 0xFF (0xF6) and 0x00 (0xF7).
- R2: Address 0x00..0x03 selects the data register of ports 0..3. 0xF6 is the port 2 direction register, 0xF7 the port 3 / open-drain control register and 0xF8 the shared ports 0-1 mode register. Mode registers read back what was written. Any other address reads 0, and a write to it changes no register.
- R3: A write to a bit that is an input stores the value in that bit's output register. While the bit stays an input, its output enable is low and a read returns the synchronized pin level, never the stored value.
- R4: Once a bit becomes an output, the stored value is driven with the output enable high from the first cycle after the mode write, and reads return the stored value.
- R5: A pin change is returned by a read only after two rising clock edges. After one edge the old level is still returned.
- R6: In register 0xF8, bits [1:0] set the port 0 low nibble, bits [4:3] set the port 0 high nibble and bits [7:6] set port 1. The codes are 00 output, 01 input and 10 address. Code 11 acts as input. The two port 0 nibbles are independent.
- R7: A group in address mode drives `addr_bus[15:8]` (port 0 nibbles, matching bit positions) or `addr_bus[7:0]` (port 1) with output enable high. Reads return the driven address bits. `addr_mode` bit 0 flags the port 0 low nibble, bit 1 the port 0 high nibble and bit 2 port 1.
- R8: Register 0xF6 bit i sets port 2 pin i as an input when 1 and as an output when 0.
- R9: When bit 0 of register 0xF7 is 1, a port 2 output bit holding 1 has its output enable low, and one holding 0 drives 0 with the output enable high. Reads of output bits return the output register.
- R10: The port 3 low nibble is always an input. Its high nibble is an output when bit 1 of register 0xF7 is 1 and an input otherwise.
- R11: `reg_rdata` follows `reg_addr` combinationally. A write strobed on one rising edge is visible on reads and on the pins right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on address |
| addr_bus | input | 16 | Address value for lines in address mode |
| pin_in | input | 32 | Asynchronous pin levels, port k at bits 8k+7..8k |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |
| addr_mode | output | 3 | Address-mode flags: port 0 low, port 0 high, port 1 |

## Verification
The clocked assertions assume the write strobe is a clean one-cycle pulse, with address and data steady around the rising edge. The bench meets this by changing every bus input only on falling edges. The synchronizer check assumes nothing about pin timing except that pins are sampled at the clock. The bench still moves pins only on falling edges, so it can count exactly two rising edges before a new level is due. Before it relies on a level, it waits at least two edges after every pin change.

// File: rtl/io_bank_pkg.sv
`timescale 1ns/1ps
package io_bank_pkg;
  localparam int PORT_W  = 8;
  localparam int N_PORTS = 4;
  localparam int ADDR_BW = 16;

  localparam logic [7:0] A_P2DIR  = 8'hF6;
  localparam logic [7:0] A_P3CTL  = 8'hF7;
  localparam logic [7:0] A_P01MOD = 8'hF8;

  localparam logic [7:0] P01MOD_RST = 8'h49;
  localparam logic [7:0] P2DIR_RST  = 8'hFF;
  localparam logic [7:0] P3CTL_RST  = 8'h00;

  typedef enum logic [1:0] {
    LINE_OUT  = 2'b00,
    LINE_IN   = 2'b01,
    LINE_ADDR = 2'b10,
    LINE_RSV  = 2'b11
  } line_mode_e;

  function automatic line_mode_e decode_mode(input logic [1:0] code);
    line_mode_e m;
    m = line_mode_e'(code);
    if (m == LINE_RSV) m = LINE_IN;
    return m;
  endfunction
endpackage

// File: rtl/io_sync2.sv
`timescale 1ns/1ps
module io_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;

  // assertion support: edges seen since reset, saturating
  logic [1:0] age_q, age_d;
  always_comb age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_d;
  end

  p_two_edge_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (sync_o == $past(async_i, 2)));
endmodule

// File: rtl/io_port_lane.sv
`timescale 1ns/1ps
module io_port_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] dir_in,
  input  logic [W-1:0] addr_sel,
  input  logic [W-1:0] addr_val,
  input  logic         od_en,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] out_q, out_d;
  logic [W-1:0] drive_val;

  always_comb begin
    out_d = out_q;
    if (wr_en) out_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      drive_val[i] = addr_sel[i] ? addr_val[i] : out_q[i];
      pin_out[i]   = od_en ? 1'b0 : drive_val[i];
      pin_oe[i]    = !dir_in[i] && !(od_en && drive_val[i]);
      rd_val[i]    = dir_in[i] ? pin_sync[i] : drive_val[i];
    end
  end

  p_write_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (out_q == $past(wdata)));
  p_outreg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(out_q));
endmodule

// File: rtl/io_port_bank.sv
`timescale 1ns/1ps
module io_port_bank
  import io_bank_pkg::*;
#(
  parameter int NW = N_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [ADDR_BW-1:0] addr_bus,
  input  logic [NW-1:0]     pin_in,
  output logic [NW-1:0]     pin_out,
  output logic [NW-1:0]     pin_oe,
  output logic [2:0]        addr_mode
);
  localparam int HALF = PORT_W / 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ni     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ni     <= rst_meta_q;
    end
  end

  // mode registers
  logic [7:0] p01mod_q, p01mod_d, p2dir_q, p2dir_d, p3ctl_q, p3ctl_d;
  always_comb begin
    p01mod_d = p01mod_q;
    p2dir_d  = p2dir_q;
    p3ctl_d  = p3ctl_q;
    if (reg_wr) begin
      if (reg_addr == A_P01MOD) p01mod_d = reg_wdata;
      if (reg_addr == A_P2DIR)  p2dir_d  = reg_wdata;
      if (reg_addr == A_P3CTL)  p3ctl_d  = reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      p01mod_q <= P01MOD_RST;
      p2dir_q  <= P2DIR_RST;
      p3ctl_q  <= P3CTL_RST;
    end else begin
      p01mod_q <= p01mod_d;
      p2dir_q  <= p2dir_d;
      p3ctl_q  <= p3ctl_d;
    end
  end

  // per-group mode decode
  line_mode_e m0lo, m0hi, m1;
  always_comb begin
    m0lo = decode_mode(p01mod_q[1:0]);
    m0hi = decode_mode(p01mod_q[4:3]);
    m1   = decode_mode(p01mod_q[7:6]);
  end

  logic [N_PORTS-1:0][PORT_W-1:0] dir_v, asel_v, aval_v, rd_v, sync_v;
  logic [N_PORTS-1:0]             od_v, wr_v;

  always_comb begin
    dir_v[0]  = {{HALF{m0hi == LINE_IN}},   {HALF{m0lo == LINE_IN}}};
    asel_v[0] = {{HALF{m0hi == LINE_ADDR}}, {HALF{m0lo == LINE_ADDR}}};
    aval_v[0] = addr_bus[ADDR_BW-1:PORT_W];
    dir_v[1]  = {PORT_W{m1 == LINE_IN}};
    asel_v[1] = {PORT_W{m1 == LINE_ADDR}};
    aval_v[1] = addr_bus[PORT_W-1:0];
    dir_v[2]  = p2dir_q;
    asel_v[2] = '0;
    aval_v[2] = '0;
    dir_v[3]  = {{HALF{!p3ctl_q[1]}}, {HALF{1'b1}}};
    asel_v[3] = '0;
    aval_v[3] = '0;
    od_v      = {1'b0, p3ctl_q[0], 2'b00};
    addr_mode = {m1 == LINE_ADDR, m0hi == LINE_ADDR, m0lo == LINE_ADDR};
  end

  generate
    for (genvar k = 0; k < N_PORTS; k++) begin : g_port
      assign wr_v[k] = reg_wr && (reg_addr == 8'(k));

      io_sync2 #(.W(PORT_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_ni),
        .async_i (pin_in[k*PORT_W +: PORT_W]),
        .sync_o  (sync_v[k])
      );

      io_port_lane #(.W(PORT_W)) u_lane (
        .clk      (clk),
        .rst_n    (rst_ni),
        .wr_en    (wr_v[k]),
        .wdata    (reg_wdata),
        .dir_in   (dir_v[k]),
        .addr_sel (asel_v[k]),
        .addr_val (aval_v[k]),
        .od_en    (od_v[k]),
        .pin_sync (sync_v[k]),
        .pin_out  (pin_out[k*PORT_W +: PORT_W]),
        .pin_oe   (pin_oe[k*PORT_W +: PORT_W]),
        .rd_val   (rd_v[k])
      );
    end
  endgenerate

  // combinational read mux
  always_comb begin
    case (reg_addr)
      8'h00:    reg_rdata = rd_v[0];
      8'h01:    reg_rdata = rd_v[1];
      8'h02:    reg_rdata = rd_v[2];
      8'h03:    reg_rdata = rd_v[3];
      A_P2DIR:  reg_rdata = p2dir_q;
      A_P3CTL:  reg_rdata = p3ctl_q;
      A_P01MOD: reg_rdata = p01mod_q;
      default:  reg_rdata = '0;
    endcase
  end

  p_mode_write_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_wr && reg_addr == A_P2DIR) |=> (p2dir_q == $past(reg_wdata)));
  p_addr_drives_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    addr_mode[2] |-> (pin_oe[2*PORT_W-1:PORT_W] == '1 &&
                      pin_out[2*PORT_W-1:PORT_W] == addr_bus[PORT_W-1:0]));
  p_opendrain_low_only_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    p3ctl_q[0] |-> (pin_out[3*PORT_W-1:2*PORT_W] == '0));
endmodule

// File: tb/io_port_bank_tb.sv
`timescale 1ns/1ps
module io_port_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] addr_bus = '0;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [2:0]  addr_mode;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  io_port_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_bus(addr_bus),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .addr_mode(addr_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a;
    #0.5;
    chk(tag, {24'h0, reg_rdata}, {24'h0, exp});
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 oe", pin_oe, 32'h0);
    chk("R1 addr_mode", {29'h0, addr_mode}, 32'h0);
    rd_chk("R1 p01mod", 8'hF8, 8'h49);
    rd_chk("R1 p2dir", 8'hF6, 8'hFF);
    rd_chk("R1 p3ctl", 8'hF7, 8'h00);
  endtask

  task automatic t_hidden();
    pin_in[23:16] = 8'h3C;
    settle();
    wr(8'h02, 8'hA5);
    rd_chk("R3 input read", 8'h02, 8'h3C);
    chk("R3 no drive", {24'h0, pin_oe[23:16]}, 32'h0);
    wr(8'hF6, 8'h0F);
    rd_chk("R11 mode readback", 8'hF6, 8'h0F);
    chk("R4 oe", {24'h0, pin_oe[23:16]}, 32'hF0);
    chk("R8 out", {28'h0, pin_out[23:20]}, 32'hA);
    rd_chk("R4 mixed read", 8'h02, 8'hAC);
  endtask

  task automatic t_sync();
    pin_in[15:8] = 8'h00;
    settle();
    @(negedge clk);
    pin_in[15:8] = 8'h5A;
    rd_chk("R5 edge0", 8'h01, 8'h00);
    @(negedge clk);
    rd_chk("R5 edge1", 8'h01, 8'h00);
    @(negedge clk);
    rd_chk("R5 edge2", 8'h01, 8'h5A);
  endtask

  task automatic t_nibble();
    wr(8'h00, 8'h96);
    pin_in[7:0] = 8'h3C;
    settle();
    wr(8'hF8, 8'h48);
    rd_chk("R6 nibble read", 8'h00, 8'h36);
    chk("R6 nibble oe", {24'h0, pin_oe[7:0]}, 32'h0F);
    wr(8'hF8, 8'h58);
    rd_chk("R6 code11 read", 8'h00, 8'h36);
    chk("R6 code11 oe", {24'h0, pin_oe[7:0]}, 32'h0F);
  endtask

  task automatic t_addr();
    addr_bus = 16'hBEEF;
    wr(8'hF8, 8'h82);
    chk("R7 oe", {16'h0, pin_oe[15:0]}, 32'hFFFF);
    chk("R7 out", {16'h0, pin_out[15:0]}, 32'hEF9E);
    chk("R7 flags", {29'h0, addr_mode}, 32'h5);
    rd_chk("R7 read p0", 8'h00, 8'h9E);
    rd_chk("R7 read p1", 8'h01, 8'hEF);
    wr(8'hF8, 8'h49);
    chk("R7 flags off", {29'h0, addr_mode}, 32'h0);
  endtask

  task automatic t_od();
    wr(8'hF6, 8'h00);
    wr(8'h02, 8'hF0);
    wr(8'hF7, 8'h01);
    chk("R9 od oe", {24'h0, pin_oe[23:16]}, 32'h0F);
    chk("R9 od out", {24'h0, pin_out[23:16]}, 32'h00);
    rd_chk("R9 od read", 8'h02, 8'hF0);
    wr(8'hF7, 8'h00);
    chk("R9 push-pull oe", {24'h0, pin_oe[23:16]}, 32'hFF);
    chk("R9 push-pull out", {24'h0, pin_out[23:16]}, 32'hF0);
  endtask

  task automatic t_p3();
    pin_in[31:24] = 8'h7E;
    settle();
    wr(8'h03, 8'hC3);
    rd_chk("R10 input read", 8'h03, 8'h7E);
    chk("R10 input oe", {24'h0, pin_oe[31:24]}, 32'h0);
    wr(8'hF7, 8'h02);
    chk("R10 hi oe", {24'h0, pin_oe[31:24]}, 32'hF0);
    chk("R10 hi out", {28'h0, pin_out[31:28]}, 32'hC);
    rd_chk("R10 mixed read", 8'h03, 8'hCE);
    rd_chk("R2 p3ctl readback", 8'hF7, 8'h02);
  endtask

  task automatic t_unmapped();
    wr(8'h10, 8'hFF);
    wr(8'hF5, 8'hFF);
    rd_chk("R2 unmapped 10", 8'h10, 8'h00);
    rd_chk("R2 unmapped F5", 8'hF5, 8'h00);
    rd_chk("R2 p2dir kept", 8'hF6, 8'h00);
    rd_chk("R2 p01mod kept", 8'hF8, 8'h49);
    rd_chk("R2 p3ctl kept", 8'hF7, 8'h02);
    chk("R2 pins kept", pin_oe, 32'hF0FF_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hidden();
    t_sync();
    t_nibble();
    t_addr();
    t_od();
    t_p3();
    t_unmapped();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule